// File: doc/BRIEF.md
# Opcode-Keyed Branch Target Buffer

This block is a small, fully associative branch target buffer with two kinds of key. An ordinary lookup presents a fetch address and gets back a predicted branch target. A dispatch lookup presents the opcode of an interpreter bytecode that was just fetched. When that lookup hits, the block returns the address of the handler, and the core can send fetch straight there. When it misses, the core runs its usual software dispatch sequence: decode, range check, then a table read to form the target.

Every entry carries a kind bit. The kind bit keeps opcode-keyed entries apart from address-keyed entries, and both kinds share one storage array. Software installs opcode-to-handler pairs through a fill port, so the opcode entries mirror the interpreter's handler table. A flush pin drops every opcode entry in a single cycle and leaves address entries in place. The interpreter uses it when it switches to another handler table.

Both request streams, lookup and fill, use a valid/ready handshake. A request is accepted on a clock edge where both valid and ready are high. Both ready outputs are low in any cycle where `flush_op` is high, and high in every other cycle. A requester that sees ready low must hold its request until a later cycle. The response has no ready signal, so the consumer must take it in the cycle it appears.

Top module: `opkey_btb`

## Requirements
- R1: After reset every entry is empty. Every lookup misses until a fill is accepted, and `rsp_valid` stays low until a lookup is accepted.
- R2: A lookup accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_hit` and `rsp_target` are meaningful only in that cycle.
- R3: A lookup with `req_is_op` = 1 is a dispatch lookup. Only `req_key[7:0]` takes part in the compare and bits 31:8 are ignored. A hit returns the handler target stored for that opcode.
- R4: An address lookup (`req_is_op` = 0) compares all 32 key bits and never matches an opcode entry. A dispatch lookup never matches an address entry, even when the numeric values are equal.
- R5: A miss drives `rsp_hit` = 0 and `rsp_target` = 0.
- R6: A fill whose kind and key match an existing entry replaces that entry's target in place. No other entry changes, and the array never holds two entries with the same kind and key.
- R7: A fill with a new kind and key goes to the lowest-numbered empty entry. If no entry is empty, it goes to the least recently used entry. An accepted fill, and otherwise a lookup hit, marks its entry as most recently used. When both happen in one cycle, only the fill counts.
- R8: When a fill and a lookup are accepted in the same cycle, the lookup sees the contents from before the fill. The fill becomes visible to lookups accepted from the next cycle on.
- R9: A cycle with `flush_op` high removes every opcode entry and keeps every address entry together with its target.
- R10: `req_ready` and `fill_ready` are low exactly in cycles where `flush_op` is high. A lookup that is not accepted produces no response, and a fill that is not accepted changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_op | input | 1 | Drop all opcode entries this cycle |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_is_op | input | 1 | 1 = opcode key, 0 = fetch address key |
| req_key | input | 32 | Lookup key |
| rsp_valid | output | 1 | Response present (one cycle after acceptance) |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_target | output | 32 | Stored target on a hit, zero on a miss |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_is_op | input | 1 | 1 = opcode entry, 0 = address entry |
| fill_key | input | 32 | Key to install (bits 31:8 ignored for opcode entries) |
| fill_target | input | 32 | Target to store |

## Verification
The hardest state to reach from the ports is a full array whose recency order has been stirred. Only in that state does the choice of victim show whether the least recently used entry is tracked correctly. The same state is needed for same-cycle fill and lookup collisions that land on an evicted entry, and for flushes that hit a mix of both kinds. The bench first fills the array completely with opcode entries and sweeps all 256 opcodes, with junk in the upper key bits. It then runs several thousand pseudo-random cycles drawn from a small key pool, so hits, evictions, in-place updates and occasional flushes interleave. Every response is compared with a recency model that uses timestamps and lives inside the bench.

// File: rtl/opkey_btb_pkg.sv
package opkey_btb_pkg;

  // Kind bit stored with every entry: which key space the tag belongs to.
  typedef enum logic {
    KIND_PC = 1'b0,
    KIND_OP = 1'b1
  } key_kind_e;

endpackage

// File: rtl/opkey_btb_store.sv
module opkey_btb_store
  import opkey_btb_pkg::*;
#(
  parameter int N     = 16,
  parameter int KEY_W = 32,
  parameter int TGT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  key_kind_e                lk_kind_i,
  input  logic [KEY_W-1:0]         lk_key_i,
  output logic                     lk_hit_o,
  output logic [$clog2(N)-1:0]     lk_idx_o,
  output logic [TGT_W-1:0]         lk_tgt_o,
  input  logic                     wr_en_i,
  input  key_kind_e                wr_kind_i,
  input  logic [KEY_W-1:0]         wr_key_i,
  input  logic [TGT_W-1:0]         wr_tgt_i,
  input  logic [$clog2(N)-1:0]     victim_i,
  output logic [$clog2(N)-1:0]     wr_idx_o
);

  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     vld_q;
  logic [N-1:0]     kind_q;
  logic [KEY_W-1:0] tag_q [N];
  logic [TGT_W-1:0] tgt_q [N];

  logic [N-1:0]     lk_match;
  logic [N-1:0]     wr_match;
  logic [IDX_W-1:0] wr_match_idx;
  logic             wr_hit;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  // Per-entry comparators; the kind bit keeps the two key spaces apart.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (kind_q[g] == logic'(lk_kind_i)) &&
                         (tag_q[g] == lk_key_i);
    assign wr_match[g] = vld_q[g] && (kind_q[g] == logic'(wr_kind_i)) &&
                         (tag_q[g] == wr_key_i);
  end

  always_comb begin
    lk_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx_o = IDX_W'(i);
    end
  end

  assign lk_hit_o = |lk_match;
  assign lk_tgt_o = tgt_q[lk_idx_o];

  always_comb begin
    wr_match_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (wr_match[i]) wr_match_idx = IDX_W'(i);
    end
  end

  assign wr_hit = |wr_match;

  // Lowest-numbered empty slot.
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_any = ~&vld_q;

  assign wr_idx_o = wr_hit   ? wr_match_idx :
                    free_any ? free_idx     : victim_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      kind_q <= '0;
    end else if (flush_i) begin
      vld_q <= vld_q & ~kind_q;
    end else if (wr_en_i) begin
      vld_q[wr_idx_o]  <= 1'b1;
      kind_q[wr_idx_o] <= logic'(wr_kind_i);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i && !flush_i) begin
      tag_q[wr_idx_o] <= wr_key_i;
      tgt_q[wr_idx_o] <= wr_tgt_i;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)) else $error("duplicate entry matched"); // R6

  AST_FLUSH_DROPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((vld_q & kind_q) == '0)) else $error("opcode entry survived flush"); // R9

  AST_FLUSH_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((vld_q & ~kind_q) == $past(vld_q & ~kind_q))) else $error("address entry lost on flush"); // R9

endmodule

// File: rtl/opkey_btb_lru.sv
module opkey_btb_lru #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_i,
  input  logic [$clog2(N)-1:0] touch_idx_i,
  output logic [$clog2(N)-1:0] victim_o
);

  localparam int IDX_W = $clog2(N);

  // rank 0 = most recently used, rank N-1 = least recently used.
  logic [IDX_W-1:0] rank_q [N];
  logic [IDX_W-1:0] touched_rank;

  assign touched_rank = rank_q[touch_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g)) begin
          rank_q[g] <= '0;
        end else if (rank_q[g] < touched_rank) begin
          rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
    end
  end

  logic [N-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < N; i++) rank_seen[rank_q[i]] = 1'b1;
  end

  AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_seen) == N) else $error("recency ranks not a permutation"); // R7

  AST_TOUCH_BECOMES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> rank_q[$past(touch_idx_i)] == '0) else $error("touched entry not most recent"); // R7

endmodule

// File: rtl/opkey_btb_rsp.sv
module opkey_btb_rsp #(
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             hit_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [TGT_W-1:0] rsp_target_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_target_o <= '0;
    end else begin
      rsp_valid_o  <= acc_i;
      rsp_hit_o    <= acc_i && hit_i;
      rsp_target_o <= (acc_i && hit_i) ? tgt_i : '0;
    end
  end

endmodule

// File: rtl/opkey_btb.sv
module opkey_btb
  import opkey_btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int OP_W    = 8,
  parameter int TGT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_op,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_op,
  input  logic [KEY_W-1:0] req_key,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TGT_W-1:0] rsp_target,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic             fill_is_op,
  input  logic [KEY_W-1:0] fill_key,
  input  logic [TGT_W-1:0] fill_target
);

  localparam int IDX_W = $clog2(ENTRIES);

  key_kind_e        lk_kind, wr_kind;
  logic [KEY_W-1:0] lk_key_n, wr_key_n;
  logic             lk_acc, wr_acc;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx, wr_idx, victim;
  logic [TGT_W-1:0] lk_tgt;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  assign req_ready  = !flush_op;
  assign fill_ready = !flush_op;
  assign lk_acc     = req_valid && req_ready;
  assign wr_acc     = fill_valid && fill_ready;

  assign lk_kind = req_is_op  ? KIND_OP : KIND_PC;
  assign wr_kind = fill_is_op ? KIND_OP : KIND_PC;

  // Opcode keys keep only the opcode field, zero-extended.
  assign lk_key_n = req_is_op  ? KEY_W'(req_key[OP_W-1:0])  : req_key;
  assign wr_key_n = fill_is_op ? KEY_W'(fill_key[OP_W-1:0]) : fill_key;

  opkey_btb_store #(
    .N     (ENTRIES),
    .KEY_W (KEY_W),
    .TGT_W (TGT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_op),
    .lk_kind_i (lk_kind),
    .lk_key_i  (lk_key_n),
    .lk_hit_o  (lk_hit),
    .lk_idx_o  (lk_idx),
    .lk_tgt_o  (lk_tgt),
    .wr_en_i   (wr_acc),
    .wr_kind_i (wr_kind),
    .wr_key_i  (wr_key_n),
    .wr_tgt_i  (fill_target),
    .victim_i  (victim),
    .wr_idx_o  (wr_idx)
  );

  // One recency update per cycle; a fill outranks a lookup hit.
  assign touch     = wr_acc || (lk_acc && lk_hit);
  assign touch_idx = wr_acc ? wr_idx : lk_idx;

  opkey_btb_lru #(
    .N (ENTRIES)
  ) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .victim_o    (victim)
  );

  opkey_btb_rsp #(
    .TGT_W (TGT_W)
  ) u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_i        (lk_acc),
    .hit_i        (lk_hit),
    .tgt_i        (lk_tgt),
    .rsp_valid_o  (rsp_valid),
    .rsp_hit_o    (rsp_hit),
    .rsp_target_o (rsp_target)
  );

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid) else $error("accepted lookup lost"); // R2

  AST_MISS_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_target == '0)) else $error("miss carries target"); // R5

  AST_STALL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && flush_op) |=> !rsp_valid) else $error("response from refused lookup"); // R10

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid) else $error("hit without response"); // R2

endmodule

// File: tb/opkey_btb_bench.sv
module opkey_btb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_op = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_is_op = 1'b0;
  logic [31:0] req_key = '0;
  logic        fill_valid = 1'b0;
  logic        fill_is_op = 1'b0;
  logic [31:0] fill_key = '0;
  logic [31:0] fill_target = '0;
  logic        req_ready, fill_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_target;

  always #5 clk = ~clk;

  opkey_btb u_opkey_btb (
    .clk(clk), .rst_n(rst_n), .flush_op(flush_op),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_op(req_is_op),
    .req_key(req_key), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_target(rsp_target), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_is_op(fill_is_op), .fill_key(fill_key), .fill_target(fill_target)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model: timestamps for recency, independent of rank logic.
  bit          m_v [16];
  bit          m_t [16];
  logic [31:0] m_k [16];
  logic [31:0] m_g [16];
  int          m_s [16];
  int          stamp;
  logic [31:0] rng = 32'h1234_5679;

  function automatic logic [31:0] nrm(bit op, logic [31:0] k);
    return op ? {24'h0, k[7:0]} : k;
  endfunction

  function automatic int find(bit op, logic [31:0] k);
    for (int i = 0; i < 16; i++)
      if (m_v[i] && m_t[i] == op && m_k[i] == nrm(op, k)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit lv, input bit lk, input logic [31:0] lkey,
                      input bit fv, input bit fk, input logic [31:0] fkey,
                      input logic [31:0] ftgt, input bit fl, input string tag);
    int  idx;
    int  j;
    bit  acc;
    logic [31:0] etgt;
    req_valid = lv; req_is_op = lk; req_key = lkey;
    fill_valid = fv; fill_is_op = fk; fill_key = fkey; fill_target = ftgt;
    flush_op = fl;
    #1;
    chk(req_ready == !fl && fill_ready == !fl, "R10 ready",
        {30'h0, req_ready, fill_ready}, {30'h0, !fl, !fl});
    acc  = lv && !fl;
    idx  = find(lk, lkey);
    etgt = (idx >= 0) ? m_g[idx] : 32'h0;
    @(negedge clk);
    chk(rsp_valid == acc, "R2 rsp_valid", {31'h0, rsp_valid}, {31'h0, acc});
    if (acc) begin
      chk(rsp_hit == (idx >= 0), tag, {31'h0, rsp_hit}, {31'h0, idx >= 0});
      chk(rsp_target == etgt, (idx >= 0) ? tag : "R5 miss target", rsp_target, etgt);
    end
    // model update
    if (fl) begin
      for (int i = 0; i < 16; i++) if (m_t[i]) m_v[i] = 1'b0;
    end else if (fv) begin
      j = find(fk, fkey);
      if (j < 0) begin
        for (int i = 15; i >= 0; i--) if (!m_v[i]) j = i;
      end
      if (j < 0) begin
        j = 0;
        for (int i = 1; i < 16; i++) if (m_s[i] < m_s[j]) j = i;
      end
      m_v[j] = 1'b1; m_t[j] = fk; m_k[j] = nrm(fk, fkey); m_g[j] = ftgt;
      stamp++; m_s[j] = stamp;
    end else if (acc && idx >= 0) begin
      stamp++; m_s[idx] = stamp;
    end
  endtask

  task automatic look(bit op, logic [31:0] k, string tag);
    step(1'b1, op, k, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, tag);
  endtask

  task automatic fill(bit op, logic [31:0] k, logic [31:0] t, string tag);
    step(1'b0, 1'b0, 32'h0, 1'b1, op, k, t, 1'b0, tag);
  endtask

  initial begin
    logic [31:0] r, r2;
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 1'b0; m_t[i] = 1'b0; m_k[i] = '0; m_g[i] = '0; m_s[i] = -i;
    end
    stamp = 0;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);

    // R1: empty array, every opcode misses
    for (int op = 0; op < 256; op++) look(1'b1, 32'(op), "R1 empty lookup");

    // R3: fill 16 opcodes, sweep all 256 with junk upper bits
    for (int i = 0; i < 16; i++)
      fill(1'b1, 32'(i * 17), 32'h4000_0000 + 32'(i * 17 * 4), "R3 fill");
    for (int op = 0; op < 256; op++)
      look(1'b1, 32'hC3A5_0000 | (32'(op) << 8 & 32'h0000_FF00) | 32'(op), "R3 opcode sweep");

    // R4: address lookups with the same numeric values miss
    for (int op = 0; op < 256; op++) look(1'b0, 32'(op), "R4 address vs opcode");

    // R7: array full, address fill evicts least recently used
    look(1'b1, 32'd0, "R7 refresh");
    fill(1'b0, 32'h0000_0011, 32'h8000_0044, "R7 evict fill");
    look(1'b0, 32'h0000_0011, "R4 address entry hit");
    look(1'b1, 32'h0000_0011, "R4 opcode same value");
    for (int i = 0; i < 16; i++) look(1'b1, 32'(i * 17), "R7 after eviction");

    // R6: in-place update
    fill(1'b1, 32'hFFFF_FF22, 32'h5555_0000, "R6 update");
    for (int i = 0; i < 16; i++) look(1'b1, 32'(i * 17), "R6 neighbours intact");

    // R8: same-cycle fill and lookup
    step(1'b1, 1'b1, 32'd51, 1'b1, 1'b1, 32'd51, 32'h7777_0000, 1'b0, "R8 old contents");
    look(1'b1, 32'd51, "R8 new contents");
    step(1'b1, 1'b1, 32'd3, 1'b1, 1'b1, 32'd3, 32'h7777_0003, 1'b0, "R8 new key not yet");
    look(1'b1, 32'd3, "R8 new key visible");

    // R9/R10: flush with a pending lookup and fill
    step(1'b1, 1'b1, 32'd3, 1'b1, 1'b0, 32'h0000_0999, 32'h1, 1'b1, "R10 refused");
    for (int op = 0; op < 256; op++) look(1'b1, 32'(op), "R9 opcodes gone");
    look(1'b0, 32'h0000_0011, "R9 address kept");
    look(1'b0, 32'h0000_0999, "R10 refused fill absent");

    // R7: pseudo-random mix over a small key pool
    for (int n = 0; n < 4000; n++) begin
      r  = rnd();
      r2 = rnd();
      step(r[0], r[1],
           r[1] ? {r[31:8], 3'b000, r[6:2]} : (32'h100 + {25'h0, r[6:2], 2'b00}),
           r[7] & r[8], r[10],
           r[10] ? {r2[31:8], 3'b000, r[15:11]} : (32'h100 + {25'h0, r[15:11], 2'b00}),
           r2, (r[21:16] == 6'd0), "R7 random mix");
    end

    req_valid = 1'b0; fill_valid = 1'b0; flush_op = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule